// File: doc/BRIEF.md
# Codec Serial Port with Data and Control Slots

This block is the device-side serial port of a voice-band codec. It runs from the master clock and generates everything the host needs to follow: a shift clock, an active-low frame-sync strobe and a flag that tells which kind of slot is in progress. Each 512-cycle conversion period holds two slots. The data slot comes first. The control slot starts at the midpoint of the period.

In the data slot, the latest converter result leaves the device on the serial output while the host shifts a new playback sample in. Both words are 16-bit two's complement. In the control slot, the host sends a control word. That word can either write one byte-wide setting register or ask for one to be returned. When a read is requested, the returned value appears in the lower half of the same outgoing word.

The converters themselves are represented by parallel ports: `adc_sample` carries the capture side in and `dac_sample` carries the playback side out. The settings are presented on `ctrl_regs` for the analog side to use.

Top module: `codec_sport`

## Requirements
- R1: A data-slot `fs_n` falling edge occurs every 512 `clk` cycles. A control-slot falling edge occurs exactly 256 cycles after each data-slot one. `frame_sec` reads 0 during data slots and 1 during control slots.
- R2: `sclk` runs at one quarter of the `clk` rate. Each `fs_n` falling edge coincides with an `sclk` rising edge. `fs_n` then stays low for 16 `sclk` periods and returns high on the 17th `sclk` rising edge of the slot.
- R3: In a data slot, `dout` carries the `adc_sample` value captured at the slot's `fs_n` fall. Bits are sent MSB first, and `dout` changes only on `sclk` rising edges.
- R4: `din` is sampled on `sclk` falling edges, MSB first. `dac_sample` takes the data-slot word on the 17th `sclk` rising edge, which is the `fs_n` rise, and not before. Control slots never change `dac_sample`.
- R5: The control word is laid out as follows. Bit 13 is the read flag, bits 12..8 are the register address, and bits 7..0 are the write data. Bits 15 and 14 are ignored. Setting registers live at addresses 1 to NREGS, and the one at address n drives `ctrl_regs[8n-1 -: 8]`.
- R6: A control word with the read flag at 0 and an address in 1..NREGS stores its data byte. The store becomes visible on `ctrl_regs` at the `fs_n` rise that ends that control slot, and not before.
- R7: Nothing is stored for address 0, for an address above NREGS, or for any word whose read flag is 1.
- R8: When the read flag is 1 and the address is in range, the control-slot `dout` word is eight 0 bits followed by the 8-bit register value. An out-of-range address returns all zeros.
- R9: When the read flag is 0, all 16 bits of the control-slot `dout` word are 0.
- R10: Reset sets register n to 17·n (0x11, 0x22, ...), `dac_sample` to 0, `fs_n` high, and `sclk`, `dout` and `frame_sec` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| adc_sample | input | 16 | Latest converter result, two's complement |
| din | input | 1 | Serial data from host |
| sclk | output | 1 | Shift clock, clk/4 |
| fs_n | output | 1 | Active-low frame strobe |
| frame_sec | output | 1 | 1 while the current slot is a control slot |
| dout | output | 1 | Serial data to host |
| dac_sample | output | 16 | Playback sample for the converter |
| ctrl_regs | output | NREGS*8 | Setting registers, register 1 in the low byte |

## Verification
The bench checks both `dac_sample` and the registers one `sclk` edge before the `fs_n` rise and again just after it. A design that latched on the 16th edge, or that committed writes as soon as the last bit arrived, would show the new value too early. It exercises reads of registers that were just written, reads of registers never touched, and writes to address 0, to an address above the top register and with the read flag set. A decoder that ignored the read flag, or that let address 0 fall through to a register, would corrupt a register that a later read then exposes. Frame spacing is timed in absolute simulation time, so an off-by-one divider or a control slot placed away from the midpoint shows up directly. A reset in the middle of a run must bring the defaults back.

// File: rtl/codec_sport_pkg.sv
package codec_sport_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int RD_BIT  = 13;
  localparam int ADDR_HI = 12;
  localparam int ADDR_LO = 8;
  localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;

  // Reset value of the setting register at address idx (1-based).
  function automatic logic [BYTE_W-1:0] reg_reset_value(input int unsigned idx);
    return BYTE_W'((idx * 17) % 256);
  endfunction
endpackage

// File: rtl/sport_frame_timer.sv
module sport_frame_timer #(
  parameter int FRAME_CLKS = 512,
  parameter int SCLK_DIV   = 4,
  parameter int WORD_BITS  = 16,
  parameter int CW         = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          sclk,
  output logic          fs_n,
  output logic          frame_sec,
  output logic          rise_ev,
  output logic          fall_ev,
  output logic          end_ev,
  output logic          slot_sec,
  output logic [CW-1:0] bit_idx
);
  localparam logic [CW-1:0] LAST_C = CW'(FRAME_CLKS - 1);
  localparam logic [CW-1:0] SLOT_C = CW'(FRAME_CLKS / 2);
  localparam logic [CW-1:0] DIV_C  = CW'(SCLK_DIV);
  localparam logic [CW-1:0] HALF_C = CW'(SCLK_DIV / 2);
  localparam logic [CW-1:0] WORD_C = CW'(WORD_BITS);

  logic [CW-1:0] cnt, nxt, loc, ph;

  // Events are decoded from the count value that this edge moves to.
  always_comb begin
    nxt      = (cnt == LAST_C) ? '0 : cnt + CW'(1);
    slot_sec = (nxt >= SLOT_C);
    loc      = slot_sec ? nxt - SLOT_C : nxt;
    ph       = loc % DIV_C;
    bit_idx  = loc / DIV_C;
    rise_ev  = (ph == '0) && (bit_idx < WORD_C);
    fall_ev  = (ph == HALF_C) && (bit_idx < WORD_C);
    end_ev   = (ph == '0) && (bit_idx == WORD_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= LAST_C;
      sclk      <= 1'b0;
      fs_n      <= 1'b1;
      frame_sec <= 1'b0;
    end else begin
      cnt       <= nxt;
      sclk      <= (ph < HALF_C);
      fs_n      <= !(bit_idx < WORD_C);
      frame_sec <= slot_sec;
    end
  end

  // Distance tracker for the frame-spacing checks.
  logic          fs_n_d, seen;
  logic [CW-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_n_d <= 1'b1;
      since  <= '0;
      seen   <= 1'b0;
    end else begin
      fs_n_d <= fs_n;
      if (fs_n_d && !fs_n && !frame_sec) begin
        since <= '0;
        seen  <= 1'b1;
      end else begin
        since <= since + CW'(1);
      end
    end
  end

  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fs_n) && !frame_sec && seen) |-> (since == LAST_C));
  p_midslot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fs_n) && frame_sec && seen) |-> (since == SLOT_C - CW'(1)));
  p_fs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fs_n) || $rose(fs_n)) |-> $rose(sclk));
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
  parameter int WORD_BITS = 16,
  parameter int CW        = 9,
  parameter int HB        = WORD_BITS / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_ev,
  input  logic                 fall_ev,
  input  logic                 end_ev,
  input  logic                 slot_sec,
  input  logic [CW-1:0]        bit_idx,
  input  logic [WORD_BITS-1:0] adc_sample,
  input  logic                 din,
  input  logic [HB-1:0]        rd_byte,
  output logic                 dout,
  output logic [WORD_BITS-1:0] dac_sample,
  output logic [WORD_BITS-3:0] ctrl_bits,
  output logic                 wr_commit
);
  localparam logic [CW-1:0] HALF_C = CW'(HB);

  logic [WORD_BITS-1:0] tx, rx, start_word;
  logic                 dac_load;

  assign start_word = slot_sec ? '0 : adc_sample;
  assign dac_load   = end_ev && !slot_sec;
  assign wr_commit  = end_ev && slot_sec;
  assign ctrl_bits  = rx[WORD_BITS-3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx         <= '0;
      rx         <= '0;
      dout       <= 1'b0;
      dac_sample <= '0;
    end else begin
      if (rise_ev) begin
        if (bit_idx == '0) begin
          dout <= start_word[WORD_BITS-1];
          tx   <= {start_word[WORD_BITS-2:0], 1'b0};
        end else if (slot_sec && bit_idx == HALF_C) begin
          // Header byte is in; the read reply fills the lower half.
          dout <= rd_byte[HB-1];
          tx   <= {rd_byte[HB-2:0], {(WORD_BITS-HB+1){1'b0}}};
        end else begin
          dout <= tx[WORD_BITS-1];
          tx   <= {tx[WORD_BITS-2:0], 1'b0};
        end
      end
      if (end_ev) dout <= 1'b0;
      if (fall_ev) rx <= {rx[WORD_BITS-2:0], din};
      if (dac_load) dac_sample <= rx;
    end
  end

  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load |=> $stable(dac_sample));
  p_sec_head_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && slot_sec && bit_idx < HALF_C) |=> !dout);
  p_dout_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev) |=> $stable(dout));
endmodule

// File: rtl/sport_ctrl_regs.sv
module sport_ctrl_regs
  import codec_sport_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [RD_BIT:0]         ctrl_bits,
  input  logic                    wr_commit,
  output logic [BYTE_W-1:0]       rd_byte,
  output logic [NREGS*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] regs [NREGS];
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              rd_req, wr_read;
  logic [BYTE_W-1:0] wr_data;

  // Mid-word view: only the header byte has arrived, sitting in the low byte.
  assign rd_req  = ctrl_bits[RD_BIT-BYTE_W];
  assign rd_addr = ctrl_bits[ADDR_HI-BYTE_W:ADDR_LO-BYTE_W];
  // End-of-word view: the complete word.
  assign wr_read = ctrl_bits[RD_BIT];
  assign wr_addr = ctrl_bits[ADDR_HI:ADDR_LO];
  assign wr_data = ctrl_bits[BYTE_W-1:0];

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_req && rd_addr == ADDR_W'(i + 1)) rd_byte = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= reg_reset_value(i + 1);
    end else if (wr_commit && !wr_read) begin
      for (int i = 0; i < NREGS; i++)
        if (wr_addr == ADDR_W'(i + 1)) regs[i] <= wr_data;
    end
  end

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_flat
    assign regs_flat[gi*BYTE_W +: BYTE_W] = regs[gi];
  end

  p_commit_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(regs_flat));
  p_noop_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_addr == '0) |=> $stable(regs_flat));
  p_read_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_read) |=> $stable(regs_flat));
endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import codec_sport_pkg::*;
#(
  parameter int FRAME_CLKS = 512,
  parameter int SCLK_DIV   = 4,
  parameter int NREGS      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       adc_sample,
  input  logic                    din,
  output logic                    sclk,
  output logic                    fs_n,
  output logic                    frame_sec,
  output logic                    dout,
  output logic [WORD_W-1:0]       dac_sample,
  output logic [NREGS*BYTE_W-1:0] ctrl_regs
);
  localparam int CW = $clog2(FRAME_CLKS);

  logic          rise_ev, fall_ev, end_ev, slot_sec, wr_commit;
  logic [CW-1:0] bit_idx;
  logic [BYTE_W-1:0] rd_byte;
  logic [RD_BIT:0]   ctrl_bits;

  sport_frame_timer #(
    .FRAME_CLKS(FRAME_CLKS), .SCLK_DIV(SCLK_DIV), .WORD_BITS(WORD_W), .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_n(fs_n), .frame_sec(frame_sec),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .end_ev(end_ev),
    .slot_sec(slot_sec), .bit_idx(bit_idx)
  );

  sport_shifter #(.WORD_BITS(WORD_W), .CW(CW), .HB(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .end_ev(end_ev), .slot_sec(slot_sec), .bit_idx(bit_idx),
    .adc_sample(adc_sample), .din(din), .rd_byte(rd_byte), .dout(dout),
    .dac_sample(dac_sample), .ctrl_bits(ctrl_bits), .wr_commit(wr_commit)
  );

  sport_ctrl_regs #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_bits(ctrl_bits), .wr_commit(wr_commit),
    .rd_byte(rd_byte), .regs_flat(ctrl_regs)
  );
endmodule

// File: tb/tb_codec_sport.sv
module tb_codec_sport;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic [15:0] adc;
    logic [15:0] dac;
    logic [15:0] ctl;
    logic [15:0] exp;
  } vec_t;

  // adc sample, host playback word, control word, expected control-slot reply
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 16'hA5C3, 16'h2100, 16'h0011},
    '{16'h8000, 16'h7FFF, 16'h02C8, 16'h0000},
    '{16'hFFFF, 16'h8000, 16'h2200, 16'h00C8},
    '{16'h0001, 16'h0000, 16'h0055, 16'h0000},
    '{16'h7FFF, 16'hFFFF, 16'h2400, 16'h0044},
    '{16'h5A5A, 16'h1357, 16'h23FF, 16'h0033},
    '{16'hC001, 16'h0F0F, 16'h2300, 16'h0033},
    '{16'h0000, 16'hFFFE, 16'h3F00, 16'h0000},
    '{16'h6000, 16'h1111, 16'h0477, 16'h0000},
    '{16'h0F00, 16'h2222, 16'hC401, 16'h0000},
    '{16'h3C3C, 16'h4444, 16'hE400, 16'h0001},
    '{16'hAAAA, 16'h5555, 16'h2000, 16'h0000},
    '{16'h1357, 16'h6666, 16'h2500, 16'h0000},
    '{16'h2468, 16'h7777, 16'h0599, 16'h0000},
    '{16'h0F0F, 16'h8888, 16'h2100, 16'h0011}
  };
  localparam logic [31:0] DEFAULTS = 32'h4433_2211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        din = 1'b0;
  logic        sclk, fs_n, frame_sec, dout;
  logic [15:0] dac_sample;
  logic [31:0] ctrl_regs;

  int tests = 0;
  int fails = 0;

  codec_sport dut (
    .clk(clk), .rst_n(rst_n), .adc_sample(adc_sample), .din(din),
    .sclk(sclk), .fs_n(fs_n), .frame_sec(frame_sec), .dout(dout),
    .dac_sample(dac_sample), .ctrl_regs(ctrl_regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Host side of one slot: drive on sclk rise, sample on sclk fall.
  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx,
                      output logic sec, output time t_fall);
    @(negedge fs_n);
    t_fall = $time;
    #1;
    sec = frame_sec;
    rx = '0;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) begin
        @(posedge sclk);
        #1;
      end
      din = tx[15-i];
      @(negedge sclk);
      #1;
      rx = {rx[14:0], dout};
    end
  endtask

  function automatic logic [31:0] apply_ctl(input logic [31:0] m, input logic [15:0] w);
    logic [4:0] a;
    a = w[12:8];
    if (!w[13] && a >= 5'd1 && a <= 5'd4) m[(int'(a) - 1)*8 +: 8] = w[7:0];
    return m;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    logic        sec;
    time         t_p, t_s, t_prev;
    logic [31:0] model;
    logic [15:0] dac_exp;

    adc_sample = VECS[0].adc;
    repeat (5) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", 64'(fs_n), 64'd1, "fs_n in reset");
    chk("R10", 64'(sclk), 64'd0, "sclk in reset");
    chk("R10", 64'(dout), 64'd0, "dout in reset");
    chk("R10", 64'(frame_sec), 64'd0, "frame_sec in reset");
    chk("R10", 64'(dac_sample), 64'd0, "dac_sample in reset");
    chk("R10", 64'(ctrl_regs), 64'(DEFAULTS), "register defaults");
    @(negedge clk);
    rst_n = 1'b1;

    model = DEFAULTS;
    dac_exp = '0;
    t_prev = 0;
    for (int i = 0; i < NV; i++) begin
      adc_sample = VECS[i].adc;
      xfer(VECS[i].dac, rx, sec, t_p);
      chk("R1", 64'(sec), 64'd0, "data slot flag");
      chk("R3", 64'(rx), 64'(VECS[i].adc), "data slot dout word");
      if (i > 0) chk("R1", 64'(t_p - t_prev), 64'(512 * CLK_PERIOD), "frame period");
      chk("R4", 64'(dac_sample), 64'(dac_exp), "dac_sample before 17th edge");
      @(posedge fs_n);
      #1;
      dac_exp = VECS[i].dac;
      chk("R4", 64'(dac_sample), 64'(dac_exp), "dac_sample after fs rise");
      t_prev = t_p;

      xfer(VECS[i].ctl, rx, sec, t_s);
      chk("R1", 64'(sec), 64'd1, "control slot flag");
      chk("R1", 64'(t_s - t_p), 64'(256 * CLK_PERIOD), "control slot offset");
      chk("R8", 64'(rx), 64'(VECS[i].exp), "control slot reply (R9 when no read)");
      chk("R6", 64'(ctrl_regs), 64'(model), "registers before fs rise");
      @(posedge fs_n);
      #1;
      model = apply_ctl(model, VECS[i].ctl);
      chk("R7", 64'(ctrl_regs), 64'(model), "registers after commit (R5 layout)");
      chk("R4", 64'(dac_sample), 64'(dac_exp), "control slot leaves dac_sample");
    end

    // R10 reset in the middle of a run brings defaults back
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", 64'(ctrl_regs), 64'(DEFAULTS), "defaults after mid-run reset");
    chk("R10", 64'(dac_sample), 64'd0, "dac_sample after mid-run reset");
    chk("R10", 64'(fs_n), 64'd1, "fs_n after mid-run reset");
    adc_sample = 16'h0BAD;
    rst_n = 1'b1;
    xfer(16'h0123, rx, sec, t_p);
    chk("R3", 64'(rx), 64'h0BAD, "first data word after reset");
    chk("R1", 64'(sec), 64'd0, "first slot after reset is data");
    @(posedge fs_n);
    #1;
    chk("R4", 64'(dac_sample), 64'h0123, "first playback word after reset");
    xfer(16'h2200, rx, sec, t_s);
    chk("R8", 64'(rx), 64'h0022, "register 2 default read after reset");
    @(posedge fs_n);
    #1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule